// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the timing skeleton of a video raster: a pixel position within the line, a line number within the field, a data-enable window, horizontal and vertical sync pulses and a field flag. The raster geometry is described per axis by four numbers: the full length, how much of it is blanking, how far the sync pulse sits after the end of active video, and how long the pulse lasts. Active video always occupies the start of each line and the start of each field.

Sync polarity is chosen separately for each axis. An interlace option splits a frame into two fields. The second field carries one extra blanking line, and its vertical sync is shifted by half a line. The geometry inputs feed a shadow copy that is refreshed only while the generator is idle or when a whole frame ends, so software may rewrite them at any time without tearing the frame being scanned.

Top module: `video_timing_gen`

## Requirements
- R1: While `enable` is low, and during reset, `pix_x` and `line_y` are 0, `field` is 0, `de` is low, and both syncs sit at their inactive level, which is the complement of the polarity bit. Dropping `enable` mid-frame returns the block to this state after one clock edge.
- R2: On the edge where `enable` is first sampled high, the position becomes (0,0). From then on, `pix_x` steps by one per clock and wraps to 0 after the value `htotal-1`. `line_y` steps by one at each wrap.
- R3: `de` is high exactly when `pix_x < htotal-hblank` and `line_y < vtotal-vblank`. A blank value larger than its total yields no active region.
- R4: Horizontal sync is active for `pix_x` in [A+`hsdelay`, A+`hsdelay`+`hswidth`), where A = `htotal-hblank`. A width of 0 gives no pulse.
- R5: In progressive mode, and in the first field of an interlaced frame, vertical sync is active for whole lines with `line_y` in [B+`vsdelay`, B+`vsdelay`+`vswidth`), where B = `vtotal-vblank`.
- R6: A polarity bit of 1 makes its sync output high while active. A polarity bit of 0 makes it low while active. The inactive level is always the opposite one.
- R7: In interlaced mode, `field` toggles at the end of every field. Field 0 lasts `vtotal` lines and field 1 lasts `vtotal+1` lines, so a frame lasts `htotal*(2*vtotal+1)` clocks.
- R8: In field 1, vertical sync begins at pixel floor(`htotal`/2) of line B+`vsdelay`. It ends just before that pixel of line B+`vsdelay`+`vswidth`.
- R9: Geometry, polarity and interlace inputs are sampled on every edge where the block is idle, and again on the edge that ends a frame (the end of field 1 when interlaced). Changes made at any other time have no effect until the next frame starts.
- R10: In progressive mode, `field` stays 0 and a frame lasts `htotal*vtotal` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the raster when high; hold idle when low |
| cfg_htotal | input | 16 | Line length in pixels |
| cfg_hblank | input | 16 | Horizontal blanking pixels |
| cfg_hsdelay | input | 16 | Pixels from end of active video to sync start |
| cfg_hswidth | input | 16 | Horizontal sync length in pixels |
| cfg_vtotal | input | 16 | Field length in lines |
| cfg_vblank | input | 8 | Vertical blanking lines |
| cfg_vsdelay | input | 8 | Lines from end of active video to sync start |
| cfg_vswidth | input | 8 | Vertical sync length in lines |
| cfg_hs_pol | input | 1 | Horizontal sync active level (1 = high) |
| cfg_vs_pol | input | 1 | Vertical sync active level (1 = high) |
| cfg_interlace | input | 1 | Interlaced scanning when high |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active video window |
| field | output | 1 | Current field of an interlaced frame |
| pix_x | output | 16 | Pixel position within the line |
| line_y | output | 16 | Line number within the field |

## Verification
The end of a frame and the reload of the shadow geometry happen on the same clock edge. The last pixel of the old frame must therefore be judged against the old values, and the first pixel of the new frame against the new ones. The bench provokes this by rewriting every geometry input a few pixels into a frame and holding the new values. It then checks that the current line still wraps at the old length and that the line after the frame boundary runs past it to the new length. The per-cycle reference model applies the same reload rule. Its own shadow copy also exposes any early or late reload at the polarity and sync boundaries.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int H_W  = 16;   // horizontal quantities and vertical total
    localparam int V_W  = 16;   // vertical total / line counter
    localparam int VB_W = 8;    // vertical blank, delay, width

    typedef struct packed {
        logic [H_W-1:0]  htotal;
        logic [H_W-1:0]  hblank;
        logic [H_W-1:0]  hsdelay;
        logic [H_W-1:0]  hswidth;
        logic [V_W-1:0]  vtotal;
        logic [VB_W-1:0] vblank;
        logic [VB_W-1:0] vsdelay;
        logic [VB_W-1:0] vswidth;
        logic            hs_pol;
        logic            vs_pol;
        logic            interlace;
    } vtg_cfg_t;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
    import vtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  vtg_cfg_t cfg_i,
    output vtg_cfg_t cfg_o
);
    vtg_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) cfg_d = cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R9: the working copy only moves on a load edge
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cfg_q == $past(cfg_q));
endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
    import vtg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           adv,
    input  logic [H_W-1:0] htotal,
    input  logic [H_W-1:0] hblank,
    input  logic [H_W-1:0] hsdelay,
    input  logic [H_W-1:0] hswidth,
    output logic [H_W-1:0] h_o,
    output logic           line_end,
    output logic           h_act,
    output logic           hsync_on,
    output logic           past_half
);
    localparam int HX = H_W + 2;

    typedef struct packed {
        logic [H_W-1:0] h;
    } hst_t;

    hst_t st_d, st_q;

    logic [HX-1:0] tot_x, act_x, sync_start, sync_stop, h_x;

    always_comb begin
        tot_x      = HX'(htotal);
        act_x      = (htotal >= hblank) ? HX'(htotal - hblank) : '0;
        sync_start = act_x + HX'(hsdelay);
        sync_stop  = sync_start + HX'(hswidth);
        h_x        = HX'(st_q.h);

        line_end  = adv && ((h_x + HX'(1)) >= tot_x);
        h_act     = h_x < act_x;
        hsync_on  = (h_x >= sync_start) && (h_x < sync_stop);
        past_half = h_x >= (tot_x >> 1);

        st_d = st_q;
        if (clr)           st_d.h = '0;
        else if (line_end) st_d.h = '0;
        else if (adv)      st_d.h = st_q.h + H_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_o = st_q.h;

    // R2: pixel counter steps by one inside the line and wraps at its end
    assert_hstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !line_end && !clr |=> h_o == $past(h_o) + H_W'(1));
    assert_hwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && !clr |=> h_o == '0);
    // R1: idle forces the pixel counter to zero
    assert_hclr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> h_o == '0);
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
    import vtg_pkg::*;
#(
    parameter bit ILACE_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    input  logic            past_half,
    input  logic [V_W-1:0]  vtotal,
    input  logic [VB_W-1:0] vblank,
    input  logic [VB_W-1:0] vsdelay,
    input  logic [VB_W-1:0] vswidth,
    input  logic            interlace,
    output logic [V_W-1:0]  v_o,
    output logic            field_o,
    output logic            frame_end,
    output logic            v_act,
    output logic            vsync_on
);
    localparam int VX = V_W + 2;

    typedef struct packed {
        logic [V_W-1:0] v;
        logic           field;
    } vst_t;

    vst_t st_d, st_q;

    logic          ilace_on;
    logic          odd_field;
    logic          last_line;
    logic          field_end;
    logic [VX-1:0] lines_x, act_x, vs_start, vs_stop, v_x;

    generate
        if (ILACE_EN) begin : g_ilace
            assign ilace_on = interlace;
        end else begin : g_prog
            assign ilace_on = interlace & 1'b0;
        end
    endgenerate

    always_comb begin
        odd_field = ilace_on && st_q.field;
        v_x       = VX'(st_q.v);
        lines_x   = VX'(vtotal) + VX'(odd_field);
        act_x     = (vtotal >= V_W'(vblank)) ? VX'(vtotal - V_W'(vblank)) : '0;
        vs_start  = act_x + VX'(vsdelay);
        vs_stop   = vs_start + VX'(vswidth);

        last_line = (v_x + VX'(1)) >= lines_x;
        field_end = step && last_line;
        frame_end = field_end && (!ilace_on || st_q.field);
        v_act     = v_x < act_x;

        if (odd_field)
            vsync_on = (vswidth != '0) &&
                       (((v_x > vs_start) && (v_x < vs_stop)) ||
                        ((v_x == vs_start) && past_half) ||
                        ((v_x == vs_stop) && !past_half));
        else
            vsync_on = (v_x >= vs_start) && (v_x < vs_stop);

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (field_end) begin
            st_d.v     = '0;
            st_d.field = ilace_on ? !st_q.field : 1'b0;
        end else if (step) begin
            st_d.v = st_q.v + V_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o     = st_q.v;
    assign field_o = st_q.field;

    // R7: line and field only move on a line boundary
    assert_vhold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !step |=> (v_o == $past(v_o)) && (field_o == $past(field_o)));
    // R7: interlaced field flips at each field end
    assert_field_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        field_end && ilace_on && !clr |=> field_o != $past(field_o));
    // R10: progressive field stays at zero after a field end
    assert_prog_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        field_end && !ilace_on |=> !field_o);
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter bit ILACE_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [H_W-1:0]  cfg_htotal,
    input  logic [H_W-1:0]  cfg_hblank,
    input  logic [H_W-1:0]  cfg_hsdelay,
    input  logic [H_W-1:0]  cfg_hswidth,
    input  logic [V_W-1:0]  cfg_vtotal,
    input  logic [VB_W-1:0] cfg_vblank,
    input  logic [VB_W-1:0] cfg_vsdelay,
    input  logic [VB_W-1:0] cfg_vswidth,
    input  logic            cfg_hs_pol,
    input  logic            cfg_vs_pol,
    input  logic            cfg_interlace,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic            field,
    output logic [H_W-1:0]  pix_x,
    output logic [V_W-1:0]  line_y
);
    vtg_cfg_t cfg_in, cfg_q;

    logic run_d, run_q;
    logic clr, adv, load;
    logic line_end, h_act, hsync_on, past_half;
    logic frame_end, v_act, vsync_on;

    always_comb begin
        cfg_in.htotal    = cfg_htotal;
        cfg_in.hblank    = cfg_hblank;
        cfg_in.hsdelay   = cfg_hsdelay;
        cfg_in.hswidth   = cfg_hswidth;
        cfg_in.vtotal    = cfg_vtotal;
        cfg_in.vblank    = cfg_vblank;
        cfg_in.vsdelay   = cfg_vsdelay;
        cfg_in.vswidth   = cfg_vswidth;
        cfg_in.hs_pol    = cfg_hs_pol;
        cfg_in.vs_pol    = cfg_vs_pol;
        cfg_in.interlace = cfg_interlace;

        run_d = enable;
        clr   = !enable;
        adv   = enable && run_q;
        load  = !run_q || frame_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    vtg_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .cfg_i (cfg_in),
        .cfg_o (cfg_q)
    );

    vtg_hcount u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .adv       (adv),
        .htotal    (cfg_q.htotal),
        .hblank    (cfg_q.hblank),
        .hsdelay   (cfg_q.hsdelay),
        .hswidth   (cfg_q.hswidth),
        .h_o       (pix_x),
        .line_end  (line_end),
        .h_act     (h_act),
        .hsync_on  (hsync_on),
        .past_half (past_half)
    );

    vtg_vcount #(.ILACE_EN(ILACE_EN)) u_vcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .step      (line_end),
        .past_half (past_half),
        .vtotal    (cfg_q.vtotal),
        .vblank    (cfg_q.vblank),
        .vsdelay   (cfg_q.vsdelay),
        .vswidth   (cfg_q.vswidth),
        .interlace (cfg_q.interlace),
        .v_o       (line_y),
        .field_o   (field),
        .frame_end (frame_end),
        .v_act     (v_act),
        .vsync_on  (vsync_on)
    );

    always_comb begin
        de    = run_q && h_act && v_act;
        hsync = (run_q && hsync_on) ? cfg_q.hs_pol : !cfg_q.hs_pol;
        vsync = (run_q && vsync_on) ? cfg_q.vs_pol : !cfg_q.vs_pol;
    end

    // R1: an idle generator sits at the origin of field 0
    assert_idle_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pix_x == '0) && (line_y == '0) && !field);
    // R4: horizontal sync never overlaps active video
    assert_de_no_hsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> hsync != cfg_q.hs_pol);
    // R5: vertical sync never overlaps active video
    assert_de_no_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> vsync != cfg_q.vs_pol);
endmodule

// File: tb/sim_video_timing_gen.sv
module sim_video_timing_gen;
    typedef struct packed {
        logic [15:0] ht, hb, hd, hw, vt;
        logic [7:0]  vb, vd, vw;
        logic        hp, vp, il;
        logic [15:0] flen, dcnt;
    } ent_t;

    // geometry, polarity, interlace, expected frame length, expected de clocks per frame
    localparam ent_t TBL [5] = '{
        '{16'd10, 16'd3, 16'd1, 16'd2, 16'd6, 8'd2, 8'd1, 8'd1, 1'b1, 1'b1, 1'b0, 16'd60,  16'd28},
        '{16'd12, 16'd4, 16'd2, 16'd3, 16'd8, 8'd3, 8'd1, 8'd2, 1'b0, 1'b0, 1'b0, 16'd96,  16'd40},
        '{16'd10, 16'd2, 16'd1, 16'd2, 16'd5, 8'd2, 8'd0, 8'd1, 1'b1, 1'b0, 1'b1, 16'd110, 16'd48},
        '{16'd9,  16'd3, 16'd0, 16'd3, 16'd6, 8'd3, 8'd1, 8'd2, 1'b0, 1'b1, 1'b1, 16'd117, 16'd36},
        '{16'd8,  16'd0, 16'd0, 16'd0, 16'd4, 8'd1, 8'd0, 8'd1, 1'b1, 1'b1, 1'b0, 16'd32,  16'd24}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] htotal = '0, hblank = '0, hsdelay = '0, hswidth = '0, vtotal = '0;
    logic [7:0]  vblank = '0, vsdelay = '0, vswidth = '0;
    logic        hs_pol = 1'b0, vs_pol = 1'b0, ilace = 1'b0;
    logic        hsync, vsync, de, field;
    logic [15:0] pix_x, line_y;

    int errors = 0;
    int checks = 0;
    int de_cnt = 0;

    // reference model state
    bit m_run = 0;
    int m_h = 0, m_v = 0, m_f = 0;
    int c_ht = 0, c_hb = 0, c_hd = 0, c_hw = 0, c_vt = 0, c_vb = 0, c_vd = 0, c_vw = 0;
    bit c_hp = 0, c_vp = 0, c_il = 0;

    always #4 clk = ~clk;

    video_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_htotal(htotal), .cfg_hblank(hblank), .cfg_hsdelay(hsdelay), .cfg_hswidth(hswidth),
        .cfg_vtotal(vtotal), .cfg_vblank(vblank), .cfg_vsdelay(vsdelay), .cfg_vswidth(vswidth),
        .cfg_hs_pol(hs_pol), .cfg_vs_pol(vs_pol), .cfg_interlace(ilace),
        .hsync(hsync), .vsync(vsync), .de(de), .field(field), .pix_x(pix_x), .line_y(line_y)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic apply(input ent_t e);
        htotal = e.ht; hblank = e.hb; hsdelay = e.hd; hswidth = e.hw; vtotal = e.vt;
        vblank = e.vb; vsdelay = e.vd; vswidth = e.vw; hs_pol = e.hp; vs_pol = e.vp; ilace = e.il;
    endtask

    // compare outputs against the model (requirements R1..R10)
    task automatic compare();
        int  hact, vact, hs0, hs1, vs0, vs1, half;
        bit  e_de, e_hs, e_vs, odd;
        string tg;
        hact = (c_ht >= c_hb) ? c_ht - c_hb : 0;
        vact = (c_vt >= c_vb) ? c_vt - c_vb : 0;
        hs0  = hact + c_hd; hs1 = hs0 + c_hw;
        vs0  = vact + c_vd; vs1 = vs0 + c_vw;
        half = c_ht / 2;
        odd  = c_il && (m_f != 0);
        e_de = m_run && (m_h < hact) && (m_v < vact);
        e_hs = m_run && (m_h >= hs0) && (m_h < hs1);
        if (odd)
            e_vs = m_run && (c_vw != 0) && ((m_v > vs0 && m_v < vs1) ||
                   (m_v == vs0 && m_h >= half) || (m_v == vs1 && m_h < half));
        else
            e_vs = m_run && (m_v >= vs0) && (m_v < vs1);
        tg = m_run ? "R2" : "R1";
        chk(pix_x == 16'(m_h), tg, "pix_x", int'(pix_x), m_h);
        chk(line_y == 16'(m_v), tg, "line_y", int'(line_y), m_v);
        chk(de == e_de, "R3", "de", int'(de), int'(e_de));
        tg = c_hp ? "R4" : "R6";
        chk(hsync == (e_hs ? c_hp : !c_hp), tg, "hsync", int'(hsync), int'(e_hs ? c_hp : !c_hp));
        tg = odd ? "R8" : (c_vp ? "R5" : "R6");
        chk(vsync == (e_vs ? c_vp : !c_vp), tg, "vsync", int'(vsync), int'(e_vs ? c_vp : !c_vp));
        tg = c_il ? "R7" : "R10";
        chk(field == (m_f != 0), tg, "field", int'(field), m_f);
    endtask

    // advance model by one edge using the inputs being driven now
    task automatic model_adv();
        bit load, fend;
        int lines;
        load = !m_run;
        fend = 0;
        if (!enable) begin
            m_h = 0; m_v = 0; m_f = 0;
        end else if (m_run) begin
            if (m_h + 1 >= c_ht) begin
                m_h   = 0;
                lines = c_vt + ((c_il && m_f != 0) ? 1 : 0);
                if (m_v + 1 >= lines) begin
                    fend = !c_il || (m_f != 0);
                    m_f  = c_il ? ((m_f != 0) ? 0 : 1) : 0;
                    m_v  = 0;
                end else m_v++;
            end else m_h++;
        end
        if (load || fend) begin
            c_ht = int'(htotal); c_hb = int'(hblank); c_hd = int'(hsdelay); c_hw = int'(hswidth);
            c_vt = int'(vtotal); c_vb = int'(vblank); c_vd = int'(vsdelay); c_vw = int'(vswidth);
            c_hp = hs_pol; c_vp = vs_pol; c_il = ilace;
        end
        m_run = enable;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            model_adv();
            @(negedge clk);
            compare();
            if (de) de_cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // reset state (R1)
        repeat (3) @(negedge clk);
        chk(de == 1'b0 && pix_x == 16'd0 && line_y == 16'd0 && field == 1'b0,
            "R1", "reset position/de", int'(de), 0);
        chk(hsync == 1'b1 && vsync == 1'b1, "R1", "reset sync level", int'({hsync, vsync}), 3);
        rst_n = 1'b1;
        tick(2);

        // table of geometries, each run for two full frames
        for (int k = 0; k < 5; k++) begin
            enable = 1'b0;
            apply(TBL[k]);
            tick(2);
            enable = 1'b1;
            de_cnt = 0;
            tick(2 * int'(TBL[k].flen));
            chk(de_cnt == 2 * int'(TBL[k].dcnt), "R3", "de clocks over two frames",
                de_cnt, 2 * int'(TBL[k].dcnt));
            tick(1);
            chk(pix_x == 16'd0 && line_y == 16'd0 && field == 1'b0,
                TBL[k].il ? "R7" : "R10", "frame length wrap", int'(pix_x) + int'(line_y), 0);
        end

        // R9: rewrite geometry mid-frame; old line length holds until frame end
        enable = 1'b0;
        apply(TBL[0]);
        tick(2);
        enable = 1'b1;
        tick(1);
        tick(3);
        apply(TBL[1]);
        tick(6);
        chk(pix_x == 16'd9, "R9", "old line still running", int'(pix_x), 9);
        tick(1);
        chk(pix_x == 16'd0 && line_y == 16'd1, "R9", "wrap at old total", int'(pix_x), 0);
        tick(50);
        chk(pix_x == 16'd0 && line_y == 16'd0, "R9", "frame boundary", int'(line_y), 0);
        tick(10);
        chk(pix_x == 16'd10, "R9", "new total in effect", int'(pix_x), 10);
        chk(hsync == 1'b0, "R6", "active-low hsync at new sync start", int'(hsync), 0);

        // R1: drop enable in the middle of field 1 of an interlaced frame
        enable = 1'b0;
        apply(TBL[2]);
        tick(2);
        enable = 1'b1;
        tick(61);
        chk(field == 1'b1, "R7", "second field reached", int'(field), 1);
        chk(line_y == 16'd1, "R7", "line in second field", int'(line_y), 1);
        enable = 1'b0;
        tick(1);
        chk(pix_x == 16'd0 && line_y == 16'd0 && field == 1'b0 && de == 1'b0,
            "R1", "disable returns to origin", int'(field), 0);
        chk(hsync == 1'b0 && vsync == 1'b1, "R1", "inactive sync levels", int'({hsync, vsync}), 1);
        tick(3);

        finish_run();
    end
endmodule